// File: doc/BRIEF.md
# Multi-Cycle Integer Execute Unit

This block is the arithmetic core of a short in-order pipeline's execute stage. A single-cycle start pulse hands it a decoded operation: an 8-bit opcode, a destination register index, a left operand and a right register operand, both read from the register file, and an 8-bit immediate. The opcode's low nibble chooses between the right register operand and the zero-extended immediate. The high nibble chooses the operation: load immediate, add, subtract, multiply or divide.

The unit captures its result when it accepts a start. It then raises busy so the upstream stages hold their instruction. After a latency fixed by the operation class, it pulses done, together with the result, the destination index and a write enable for the register file. Fetch, decode and the register file are outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: After reset, busy_o, done_o and wen_o are low and result_o is zero.
- R2: Opcode 0x00 loads the zero-extended immediate into the result. The left and right register operands have no effect.
- R3: Opcode 0x10 gives left + right register and 0x11 gives left + immediate, modulo 2^DATA_W. Bit 0 of the opcode set means the immediate replaces the right register operand, and the right register then has no effect.
- R4: Opcode 0x20 gives left − right register and 0x21 gives left − immediate, modulo 2^DATA_W.
- R5: Opcode 0x30 gives left × right register and 0x31 gives left × immediate. Only the low DATA_W bits of the product are kept.
- R6: Opcode 0x40 gives floor(left / right register) and 0x41 gives floor(left / immediate). A zero divisor gives all ones.
- R7: done_o is a one-cycle pulse. It appears exactly 1 cycle after the accepting clock edge for set, add and sub, 2 cycles after it for mul, and 4 cycles after it for div.
- R8: busy_o is high from the cycle after an accepted start up to and including the done cycle, and low otherwise.
- R9: A start raised while busy_o is high is ignored. The pending result, destination and done timing are unchanged, and no extra operation follows.
- R10: Any other opcode completes with done after 1 cycle and wen_o low. wen_o is high with done for every opcode listed in R2 to R6.
- R11: dest_o carries the destination index sampled with the accepted start, and it is valid while done_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Issue pulse for a new operation |
| opcode_i | input | 8 | Operation code |
| dest_i | input | IDX_W | Destination register index |
| lhs_i | input | DATA_W | Left register operand |
| rhs_i | input | DATA_W | Right register operand |
| imm_i | input | IMM_W | Immediate field |
| busy_o | output | 1 | Operation in flight; upstream stalls |
| done_o | output | 1 | Result valid this cycle |
| wen_o | output | 1 | Register file write enable, qualified by done |
| dest_o | output | IDX_W | Destination index of the completing operation |
| result_o | output | DATA_W | Result value |

## Verification
The bench builds the unit with DATA_W = 8 and keeps the 8-bit immediate and the 2/4-cycle latencies. Every left operand value can then be swept against a spread of right operands and immediates, for each of the nine opcodes. That sweep reaches add and multiply wrap-around, subtract borrow, division by zero and by one, and exact floor boundaries, with the results computed arithmetically in the bench. All 247 remaining opcodes are also swept for the no-write path. Starts held high through a busy window show that they are ignored.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int OPC_W = 8;

  typedef enum logic [2:0] {
    CL_SET, CL_ADD, CL_SUB, CL_MUL, CL_DIV, CL_BAD
  } op_class_e;

  typedef struct packed {
    op_class_e cls;
    logic      use_imm;
    logic      wr;
  } op_dec_t;

  function automatic op_dec_t decode_op(logic [OPC_W-1:0] opc);
    op_dec_t d;
    d.use_imm = opc[0];
    d.wr      = 1'b1;
    d.cls     = CL_BAD;
    if (opc[3:1] == 3'b000) begin
      unique case (opc[7:4])
        4'h0:    d.cls = opc[0] ? CL_BAD : CL_SET;
        4'h1:    d.cls = CL_ADD;
        4'h2:    d.cls = CL_SUB;
        4'h3:    d.cls = CL_MUL;
        4'h4:    d.cls = CL_DIV;
        default: d.cls = CL_BAD;
      endcase
    end
    // set always takes the immediate
    if (d.cls == CL_SET) d.use_imm = 1'b1;
    if (d.cls == CL_BAD) d.wr = 1'b0;
    return d;
  endfunction
endpackage

// File: rtl/exu_opsel.sv
module exu_opsel
  import exu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [DATA_W-1:0] rhs_i,
  input  logic [IMM_W-1:0]  imm_i,
  output op_dec_t           dec_o,
  output logic [DATA_W-1:0] rhs_sel_o
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W >= DATA_W) begin : g_imm_trunc
      assign imm_ext = imm_i[DATA_W-1:0];
    end else begin : g_imm_zext
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_i};
    end
  endgenerate

  assign dec_o     = decode_op(opcode_i);
  assign rhs_sel_o = dec_o.use_imm ? imm_ext : rhs_i;
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_class_e         cls_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  logic [2*DATA_W-1:0] prod;
  logic [DATA_W-1:0]   quot;

  assign prod = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};
  // zero divisor saturates instead of trapping
  assign quot = (b_i == '0) ? '1 : a_i / b_i;

  always_comb begin
    unique case (cls_i)
      CL_SET:  res_o = b_i;
      CL_ADD:  res_o = a_i + b_i;
      CL_SUB:  res_o = a_i - b_i;
      CL_MUL:  res_o = prod[DATA_W-1:0];
      CL_DIV:  res_o = quot;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/exu_ctrl.sv
module exu_ctrl
  import exu_pkg::*;
#(
  parameter int LAT_ALU = 1,
  parameter int LAT_MUL = 2,
  parameter int LAT_DIV = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  op_class_e cls_i,
  output logic      accept_o,
  output logic      busy_o,
  output logic      done_o
);
  localparam int LAT_MAX = (LAT_DIV > LAT_MUL) ?
                           ((LAT_DIV > LAT_ALU) ? LAT_DIV : LAT_ALU) :
                           ((LAT_MUL > LAT_ALU) ? LAT_MUL : LAT_ALU);
  localparam int CNT_W   = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_init;

  always_comb begin
    unique case (cls_i)
      CL_MUL:  cnt_init = CNT_W'(LAT_MUL - 1);
      CL_DIV:  cnt_init = CNT_W'(LAT_DIV - 1);
      default: cnt_init = CNT_W'(LAT_ALU - 1);
    endcase
  end

  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;
  assign done_o   = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      cnt_q  <= cnt_init;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import exu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 8,
  parameter int IDX_W   = 4,
  parameter int LAT_MUL = 2,
  parameter int LAT_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [IDX_W-1:0]  dest_i,
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wen_o,
  output logic [IDX_W-1:0]  dest_o,
  output logic [DATA_W-1:0] result_o
);
  op_dec_t           dec;
  logic [DATA_W-1:0] rhs_sel;
  logic [DATA_W-1:0] alu_res;
  logic              accept;
  logic [DATA_W-1:0] result_q;
  logic [IDX_W-1:0]  dest_q;
  logic              wr_q;

  exu_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .opcode_i (opcode_i),
    .rhs_i    (rhs_i),
    .imm_i    (imm_i),
    .dec_o    (dec),
    .rhs_sel_o(rhs_sel)
  );

  exu_alu #(.DATA_W(DATA_W)) u_alu (
    .cls_i(dec.cls),
    .a_i  (lhs_i),
    .b_i  (rhs_sel),
    .res_o(alu_res)
  );

  exu_ctrl #(.LAT_ALU(1), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cls_i   (dec.cls),
    .accept_o(accept),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  // result is formed at issue and held; the counter only models latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      dest_q   <= '0;
      wr_q     <= 1'b0;
    end else if (accept) begin
      result_q <= alu_res;
      dest_q   <= dest_i;
      wr_q     <= dec.wr;
    end
  end

  assign result_o = result_q;
  assign dest_o   = dest_q;
  assign wen_o    = done_o && wr_q;
endmodule

// File: rtl/exu_chk.sv
module exu_chk #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 4,
  parameter int LAT_MUL = 2,
  parameter int LAT_DIV = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [7:0]        opcode_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              wen_o,
  input logic [IDX_W-1:0]  dest_o,
  input logic [DATA_W-1:0] result_o
);
  logic [7:0] cyc_q;
  logic [7:0] exp_lat_q;
  logic       exp_wr_q;
  logic [7:0] lat_now;
  logic       known_now;

  always_comb begin
    known_now = 1'b1;
    lat_now   = 8'd1;
    case (opcode_i)
      8'h00, 8'h10, 8'h11, 8'h20, 8'h21: lat_now = 8'd1;
      8'h30, 8'h31: lat_now = 8'(LAT_MUL);
      8'h40, 8'h41: lat_now = 8'(LAT_DIV);
      default: known_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q     <= '0;
      exp_lat_q <= '0;
      exp_wr_q  <= 1'b0;
    end else if (start_i && !busy_o) begin
      cyc_q     <= 8'd1;
      exp_lat_q <= lat_now;
      exp_wr_q  <= known_now;
    end else if (busy_o) begin
      cyc_q     <= cyc_q + 8'd1;
    end
  end

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc_q == exp_lat_q));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_in_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  assert_busy_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  assert_busy_starts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (busy_o && $stable(result_o) && $stable(dest_o)));
  assert_wen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wen_o == exp_wr_q));
  assert_wen_qual_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wen_o |-> done_o);
endmodule

bind int_exec_unit exu_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .LAT_MUL(LAT_MUL), .LAT_DIV(LAT_DIV)
) u_exu_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .opcode_i(opcode_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .wen_o   (wen_o),
  .dest_o  (dest_o),
  .result_o(result_o)
);

// File: tb/tb_int_exec_unit.sv
module tb_int_exec_unit;
  localparam int DW = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    opc = '0;
  logic [IW-1:0] dst = '0;
  logic [DW-1:0] lhs = '0;
  logic [DW-1:0] rhs = '0;
  logic [7:0]    imm = '0;
  logic          busy, done, wen;
  logic [IW-1:0] dout;
  logic [DW-1:0] res;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  int_exec_unit #(.DATA_W(DW), .IMM_W(8), .IDX_W(IW), .LAT_MUL(2), .LAT_DIV(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opc), .dest_i(dst),
    .lhs_i(lhs), .rhs_i(rhs), .imm_i(imm), .busy_o(busy), .done_o(done),
    .wen_o(wen), .dest_o(dout), .result_o(res)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s opc=%02h: act=%0h exp=%0h", tag, opc, act, exp);
    end
  endtask

  function automatic bit is_known(input logic [7:0] o);
    return o inside {8'h00, 8'h10, 8'h11, 8'h20, 8'h21, 8'h30, 8'h31, 8'h40, 8'h41};
  endfunction

  function automatic int lat_of(input logic [7:0] o);
    if (o[7:4] == 4'h3 && is_known(o)) return 2;
    if (o[7:4] == 4'h4 && is_known(o)) return 4;
    return 1;
  endfunction

  function automatic logic [DW-1:0] model(input logic [7:0] o, input int l, input int r, input int im);
    int b;
    int v;
    b = o[0] ? im : r;
    case (o[7:4])
      4'h0: v = im;
      4'h1: v = l + b;
      4'h2: v = l - b;
      4'h3: v = l * b;
      default: v = (b == 0) ? 255 : l / b;
    endcase
    return DW'(v & 255);
  endfunction

  // issue one operation and follow it to completion; hold_start keeps start
  // high through the busy window to show it is ignored
  task automatic run_op(input logic [7:0] o, input logic [IW-1:0] d, input logic [DW-1:0] l,
                        input logic [DW-1:0] r, input logic [7:0] im, input bit hold_start);
    logic [DW-1:0] e_res;
    int e_lat;
    int got;
    bit wr;
    e_lat = lat_of(o);
    wr    = is_known(o);
    e_res = model(o, int'(l), int'(r), int'(im));
    @(negedge clk);
    start = 1'b1; opc = o; dst = d; lhs = l; rhs = r; imm = im;
    @(negedge clk);
    if (hold_start) begin
      opc = 8'h10; dst = ~d; lhs = 8'h01; rhs = 8'h01;
    end else begin
      start = 1'b0; lhs = ~l; rhs = ~r; imm = ~im; dst = ~d;
    end
    got = 0;
    for (int k = 1; k <= 8; k++) begin
      if (k > 1) @(negedge clk);
      if (!busy) begin
        chk(0, "R8 busy low before done", k, e_lat);
        break;
      end
      if (done) begin got = k; break; end
    end
    chk(got == e_lat, hold_start ? "R9 latency with start held" : "R7 latency", got, e_lat);
    chk(wen == wr, "R10 write enable", int'(wen), int'(wr));
    if (got != 0) begin
      chk(dout == d, hold_start ? "R9 dest" : "R11 dest", int'(dout), int'(d));
      if (wr)
        chk(res == e_res, hold_start ? "R9 result" : "R3/R4/R5/R6/R2 result", int'(res), int'(e_res));
    end
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done, "R8 idle after done", int'({busy, done}), 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [9];
    logic [7:0] vals [12];
    ops  = '{8'h00, 8'h10, 8'h11, 8'h20, 8'h21, 8'h30, 8'h31, 8'h40, 8'h41};
    vals = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7, 8'd15, 8'd16, 8'd100, 8'd127, 8'd128, 8'd200, 8'd255};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !wen, "R1 reset flags", int'({busy, done, wen}), 0);
    chk(res == '0, "R1 reset result", int'(res), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 idle after reset", int'(busy), 0);

    // R2..R6 sweeps; imm forms drive rhs with junk to show it is ignored (R3)
    foreach (ops[i]) begin
      for (int l = 0; l < 256; l++) begin
        foreach (vals[j]) begin
          if (ops[i][0] || ops[i] == 8'h00)
            run_op(ops[i], IW'(l + j), DW'(l), ~vals[j], vals[j], 1'b0);
          else
            run_op(ops[i], IW'(l + j), DW'(l), vals[j], ~vals[j], 1'b0);
        end
      end
    end

    // R9: starts held during busy for each latency class
    run_op(8'h41, 4'd5, 8'd200, 8'd0, 8'd7, 1'b1);
    run_op(8'h30, 4'd9, 8'd20, 8'd13, 8'd0, 1'b1);
    run_op(8'h00, 4'd3, 8'd0, 8'd0, 8'hA5, 1'b1);
    run_op(8'h40, 4'd12, 8'd99, 8'd0, 8'd3, 1'b1);

    // R10: every other opcode
    for (int o = 0; o < 256; o++)
      if (!is_known(8'(o))) run_op(8'(o), 4'd6, 8'd10, 8'd20, 8'd30, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule